// File: doc/BRIEF.md
# Per-port pin event interrupt detector

This block watches the eight (by default) input pins of one general-purpose port and turns pin activity into interrupt requests. Each pin is set, through a packed type register, to trigger on a rising edge, a falling edge, either edge, a high level or a low level. A detected condition sets that pin's pending status bit. A per-pin enable register selects which pending bits may raise the single interrupt line, which is high whenever some pin is both pending and enabled.

Software clears edge-triggered pending bits by writing ones to a clear register, normally before it services the pin, so that a following edge is caught again at once. Level-triggered pins report the live state of their active level, so a clear does nothing while the level is still present. The enable register can be written as a whole, or through a masked alias that changes only the selected bits, so that two agents never have to read, modify and write it. Pin inputs must already be synchronized to the block clock. Interrupt outputs of several ports are combined elsewhere.

Top module: `pin_event_irq`

## Requirements
- R1: While reset is high and on the first cycle after it, the type register, the enable register, `status_o`, `pend_o` and `irq_o` are all zero (type zero means level-low mode for every pin).
- R2: The type register (write address 0) gives pin n a polarity bit at bit n, an edge-select bit at bit n+NPIN and an any-edge bit at bit n+2*NPIN; {any, edge, polarity} = {0,1,1} is rising-edge mode: `status_o[n]` sets at the clock edge where the pin is sampled 1 after being sampled 0 on the edge before.
- R3: {any, edge, polarity} = {0,1,0} is falling-edge mode: `status_o[n]` sets on a sampled 1-to-0 change of the pin.
- R4: {any, edge, polarity} = {1,1,0} is any-edge mode: `status_o[n]` sets on a sampled change of the pin in either direction.
- R5: With the edge-select bit 0 the pin is level-sensitive: polarity 1 (level high) makes `status_o[n]` equal the pin level sampled at the previous clock edge, polarity 0 (level low) makes it equal the inverted level.
- R6: A write of data D to the clear register (write address 3) clears every edge-mode status bit n with D[n] = 1, at the same clock edge; bits with D[n] = 0 are not changed.
- R7: A clear written to a level-mode pin whose level is still active has no effect: its status bit stays 1.
- R8: When a clear of bit n and a new active edge of pin n arrive at the same clock edge, the edge wins and `status_o[n]` is 1 afterwards.
- R9: Status bits set regardless of the enable register; `pend_o` equals status AND enable one clock later, and `irq_o` is 1 exactly when `pend_o` is non-zero, so a pin pending while disabled raises `irq_o` once it is enabled.
- R10: A write of data D to address 1 loads the enable register with D[NPIN-1:0]; a write to address 2 (masked alias) replaces only the enable bits n with D[n+NPIN] = 1, by D[n], and keeps all others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | NPIN | Synchronized pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address: 0 type, 1 enable, 2 enable masked, 3 clear |
| wr_data | input | 3*NPIN | Register write data |
| status_o | output | NPIN | Pending status per pin |
| pend_o | output | NPIN | Registered status AND enable |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default NPIN of 8, which makes the type register 24 bits wide and places the edge-select and any-edge fields at bits 8 and 16, and puts the masked-enable mask in bits 15:8. At this width every one of the five trigger modes, the masked enable update across several bit positions, and the case of two edge pins pending with only one cleared can be driven by short directed sequences, together with the same-cycle clear-and-edge race and the pending-while-disabled case.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;

  // write addresses of the register bus
  typedef enum logic [1:0] {
    ADR_TYPE   = 2'd0,
    ADR_ENA    = 2'd1,
    ADR_ENA_MS = 2'd2,
    ADR_CLEAR  = 2'd3
  } reg_addr_e;

  // trigger modes decoded per pin
  typedef enum logic [2:0] {
    TRG_LVL_LO = 3'd0,
    TRG_LVL_HI = 3'd1,
    TRG_RISE   = 3'd2,
    TRG_FALL   = 3'd3,
    TRG_ANY    = 3'd4
  } trig_mode_e;

  // {any, edge, polarity} to mode; level with any-edge set stays level
  function automatic trig_mode_e decode_mode(input logic any_b,
                                             input logic edge_b,
                                             input logic pol_b);
    trig_mode_e m;
    if (!edge_b)      m = pol_b ? TRG_LVL_HI : TRG_LVL_LO;
    else if (any_b)   m = TRG_ANY;
    else              m = pol_b ? TRG_RISE : TRG_FALL;
    return m;
  endfunction

endpackage

// File: rtl/pin_event_regs.sv
module pin_event_regs
  import pin_event_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [3*NPIN-1:0] wr_data,
  output logic [NPIN-1:0]   pol_q,
  output logic [NPIN-1:0]   edge_q,
  output logic [NPIN-1:0]   any_q,
  output logic [NPIN-1:0]   enable_q,
  output logic [NPIN-1:0]   clr_vec
);

  localparam int EDGE_LO = NPIN;
  localparam int ANY_LO  = 2 * NPIN;

  logic hit_type, hit_ena, hit_ms, hit_clr;
  logic [NPIN-1:0] ms_mask, ms_val, ena_next;

  always_comb begin
    hit_type = wr_en && (wr_addr == ADR_TYPE);
    hit_ena  = wr_en && (wr_addr == ADR_ENA);
    hit_ms   = wr_en && (wr_addr == ADR_ENA_MS);
    hit_clr  = wr_en && (wr_addr == ADR_CLEAR);
    ms_mask  = wr_data[EDGE_LO +: NPIN];
    ms_val   = wr_data[0 +: NPIN];
  end

  always_comb begin
    ena_next = enable_q;
    if (hit_ena)     ena_next = wr_data[0 +: NPIN];
    else if (hit_ms) ena_next = (enable_q & ~ms_mask) | (ms_val & ms_mask);
  end

  // clear strobe is a one-cycle pulse straight from the bus
  always_comb clr_vec = hit_clr ? wr_data[0 +: NPIN] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q    <= '0;
      edge_q   <= '0;
      any_q    <= '0;
      enable_q <= '0;
    end else begin
      if (hit_type) begin
        pol_q  <= wr_data[0       +: NPIN];
        edge_q <= wr_data[EDGE_LO +: NPIN];
        any_q  <= wr_data[ANY_LO  +: NPIN];
      end
      enable_q <= ena_next;
    end
  end

endmodule

// File: rtl/pin_event_cell.sv
module pin_event_cell
  import pin_event_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic pol,
  input  logic edge_sel,
  input  logic any_sel,
  input  logic clr,
  output logic status
);

  logic       prev_q;
  logic       rise, fall, hit;
  logic       status_d;
  trig_mode_e mode;

  // previous sample, kept running during reset
  always_ff @(posedge clk) prev_q <= pin;

  always_comb begin
    rise = pin & ~prev_q;
    fall = ~pin & prev_q;
    mode = decode_mode(any_sel, edge_sel, pol);
    hit  = 1'b0;
    unique case (mode)
      TRG_RISE:   hit = rise;
      TRG_FALL:   hit = fall;
      TRG_ANY:    hit = rise | fall;
      TRG_LVL_HI: hit = pin;
      TRG_LVL_LO: hit = ~pin;
      default:    hit = 1'b0;
    endcase
  end

  always_comb begin
    if (!edge_sel) status_d = hit;                 // level follows pin
    else           status_d = (status & ~clr) | hit; // new edge beats clear
  end

  always_ff @(posedge clk) begin
    if (rst) status <= 1'b0;
    else     status <= status_d;
  end

endmodule

// File: rtl/pin_event_out.sv
module pin_event_out #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] status,
  input  logic [NPIN-1:0] enable,
  output logic [NPIN-1:0] pend_q,
  output logic            irq_q
);

  logic [NPIN-1:0] pend_d;

  always_comb pend_d = status & enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= |pend_d;
    end
  end

endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
  import pin_event_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIN-1:0]   pin_i,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [3*NPIN-1:0] wr_data,
  output logic [NPIN-1:0]   status_o,
  output logic [NPIN-1:0]   pend_o,
  output logic              irq_o
);

  logic [NPIN-1:0] pol, edge_sel, any_sel, enable, clr_vec;
  logic [NPIN-1:0] status;

  pin_event_regs #(.NPIN(NPIN)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pol_q    (pol),
    .edge_q   (edge_sel),
    .any_q    (any_sel),
    .enable_q (enable),
    .clr_vec  (clr_vec)
  );

  for (genvar n = 0; n < NPIN; n++) begin : g_cell
    pin_event_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .pin      (pin_i[n]),
      .pol      (pol[n]),
      .edge_sel (edge_sel[n]),
      .any_sel  (any_sel[n]),
      .clr      (clr_vec[n]),
      .status   (status[n])
    );
  end

  pin_event_out #(.NPIN(NPIN)) u_out (
    .clk    (clk),
    .rst    (rst),
    .status (status),
    .enable (enable),
    .pend_q (pend_o),
    .irq_q  (irq_o)
  );

  assign status_o = status;

endmodule

// File: rtl/pin_event_irq_chk.sv
module pin_event_irq_chk #(
  parameter int NPIN = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [NPIN-1:0]   pin_i,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [3*NPIN-1:0] wr_data,
  input logic [NPIN-1:0]   status_o,
  input logic [NPIN-1:0]   pend_o,
  input logic              irq_o,
  input logic [NPIN-1:0]   pol,
  input logic [NPIN-1:0]   edge_sel,
  input logic [NPIN-1:0]   enable
);

  logic [NPIN-1:0] clr_seen;
  logic [NPIN-1:0] ms_mask, ms_val;

  always_comb begin
    clr_seen = (wr_en && wr_addr == 2'd3) ? wr_data[NPIN-1:0] : '0;
    ms_mask  = wr_data[2*NPIN-1:NPIN];
    ms_val   = wr_data[NPIN-1:0];
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (status_o == '0 && pend_o == '0 && !irq_o && enable == '0));

  // R5
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ((status_o ^ $past(pin_i)) & $past(~edge_sel & pol)) == '0);

  // R6
  edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(status_o) & ~status_o) & $past(edge_sel) & ~$past(clr_seen)) == '0);

  // R9
  pend_track_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pend_o == $past(status_o & enable)));

  // R9
  irq_or_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (pend_o != '0));

  // R10
  masked_ena_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd2) |=>
      enable == (($past(enable) & ~$past(ms_mask)) | ($past(ms_val) & $past(ms_mask))));

endmodule

bind pin_event_irq pin_event_irq_chk #(.NPIN(NPIN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pin_i    (pin_i),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .status_o (status_o),
  .pend_o   (pend_o),
  .irq_o    (irq_o),
  .pol      (pol),
  .edge_sel (edge_sel),
  .enable   (enable)
);

// File: tb/pin_event_irq_tb.sv
`timescale 1ns/1ps
module pin_event_irq_tb;

  localparam int NPIN = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic [NPIN-1:0]   pin_i;
  logic              wr_en;
  logic [1:0]        wr_addr;
  logic [3*NPIN-1:0] wr_data;
  logic [NPIN-1:0]   status_o, pend_o;
  logic              irq_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  pin_event_irq #(.NPIN(NPIN)) u_dut (
    .clk(clk), .rst(rst), .pin_i(pin_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .status_o(status_o), .pend_o(pend_o), .irq_o(irq_o)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3*NPIN-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset();
    rst = 1'b1; pin_i = '1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) step();
    chk("R1", "status in reset", 32'(status_o), 0);
    rst = 1'b0;
    step();
    chk("R1", "status after reset", 32'(status_o), 0);
    chk("R1", "pend after reset", 32'(pend_o), 0);
    chk("R1", "irq after reset", 32'(irq_o), 0);
  endtask

  task automatic t_rise();
    wr(2'd0, 24'h000101);
    pin_i[0] = 1'b0; step();
    chk("R2", "no set on fall", 32'(status_o), 0);
    pin_i[0] = 1'b1; step();
    chk("R2", "set on rise", 32'(status_o), 32'h01);
    wr(2'd3, 24'h0000FF);
    chk("R6", "rise cleared", 32'(status_o), 0);
  endtask

  task automatic t_fall();
    wr(2'd0, 24'h000100);
    pin_i[0] = 1'b0; step();
    chk("R3", "set on fall", 32'(status_o), 32'h01);
    wr(2'd3, 24'h000001);
    pin_i[0] = 1'b1; step();
    chk("R3", "no set on rise", 32'(status_o), 0);
  endtask

  task automatic t_any();
    wr(2'd0, 24'h010100);
    pin_i[0] = 1'b0; step();
    chk("R4", "set on fall", 32'(status_o), 32'h01);
    wr(2'd3, 24'h000001);
    chk("R4", "cleared", 32'(status_o), 0);
    pin_i[0] = 1'b1; step();
    chk("R4", "set on rise", 32'(status_o), 32'h01);
    wr(2'd3, 24'h000001);
  endtask

  task automatic t_level();
    wr(2'd0, 24'h000001);          // pin0 level high, others level low
    step();
    chk("R5", "level high active", 32'(status_o), 32'h01);
    wr(2'd3, 24'h000001);
    chk("R7", "clear ignored while active", 32'(status_o), 32'h01);
    pin_i[0] = 1'b0; step();
    chk("R5", "level high inactive", 32'(status_o), 0);
    wr(2'd0, 24'h000000);          // pin0 level low
    step();
    chk("R5", "level low active", 32'(status_o), 32'h01);
    pin_i[0] = 1'b1; step();
    chk("R5", "level low inactive", 32'(status_o), 0);
  endtask

  task automatic t_partial_clear();
    wr(2'd0, 24'h000303);          // rising on pins 0 and 1
    pin_i[1:0] = 2'b00; step();
    pin_i[1:0] = 2'b11; step();
    chk("R2", "two pins pending", 32'(status_o), 32'h03);
    wr(2'd3, 24'h000001);
    chk("R6", "zero bit kept", 32'(status_o), 32'h02);
    wr(2'd3, 24'h000002);
    chk("R6", "second cleared", 32'(status_o), 0);
  endtask

  task automatic t_race();
    wr(2'd0, 24'h000101);
    pin_i[0] = 1'b0; step();
    pin_i[0] = 1'b1; step();
    pin_i[0] = 1'b0; step();
    chk("R8", "pending before race", 32'(status_o), 32'h01);
    pin_i[0] = 1'b1;
    wr(2'd3, 24'h000001);          // clear and rise on the same edge
    chk("R8", "edge wins over clear", 32'(status_o), 32'h01);
    wr(2'd3, 24'h000001);
    chk("R8", "plain clear after race", 32'(status_o), 0);
  endtask

  task automatic t_enable();
    pin_i[0] = 1'b0; step();
    pin_i[0] = 1'b1; step();
    step();
    chk("R9", "latched while disabled", 32'(status_o), 32'h01);
    chk("R9", "irq low while disabled", 32'(irq_o), 0);
    wr(2'd1, 24'h000001);
    step();
    chk("R9", "pend after enable", 32'(pend_o), 32'h01);
    chk("R9", "irq after enable", 32'(irq_o), 1);
    wr(2'd3, 24'h000001);
    step();
    chk("R9", "irq drops after clear", 32'(irq_o), 0);
  endtask

  task automatic t_mask();
    pin_i = '1;
    wr(2'd0, 24'h0000FF);          // all pins level high: status all ones
    step();
    chk("R5", "all level high", 32'(status_o), 32'hFF);
    wr(2'd2, 24'h000F05);
    step();
    chk("R10", "masked write 1", 32'(pend_o), 32'h05);
    wr(2'd2, 24'h000C08);
    step();
    chk("R10", "masked write 2", 32'(pend_o), 32'h09);
    wr(2'd1, 24'h0000A0);
    step();
    chk("R10", "full write", 32'(pend_o), 32'hA0);
    chk("R9", "irq with pend", 32'(irq_o), 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_rise();
        t_fall();
        t_any();
        t_level();
        t_partial_clear();
        t_race();
        t_enable();
        t_mask();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule